// File: doc/BRIEF.md
# Byte Write and Bus Direction Control

This block sits between the synchronous control inputs of a common-I/O memory and its storage core. On every clock it turns the active-low global write, the active-low byte-write enable and the per-byte active-low selects into an active-high per-byte write mask. The storage core uses that mask at the same rising edge. The address controller tells the block two things each clock: whether the device is selected, and which address strobe (processor or controller) began a new access. The block uses this to apply the first-cycle rules. A processor-strobe start is always a read. A controller-strobe start may write at once.

The block also keeps a small registered view of the bus phase: deselected, reading or writing. From it, the block decides whether the shared data pins may drive during the next cycle. The drive enable is that registered permission ANDed with the asynchronous output enable. The pins therefore float while a write is in progress, while the device is deselected, in the first read cycle after deselect, and after a write until a strobe starts a new read.

Top module: `bwc_ctrl`

## Requirements
- R1: When the device is selected and the clock is not a processor-strobe start, a low global write sets all mask bits to 1. The byte-write enable and the byte selects have no effect in that case.
- R2: When global write is high and byte-write enable is low, mask bit i is 1 exactly when byte select i is low. Any combination of selects is allowed. Bit i of the mask and of the selects refers to byte lane i.
- R3: The clock is a read and the mask is all zeros in two cases: global write and byte-write enable are both high, or byte-write enable is low and every byte select is high.
- R4: In a clock flagged as a processor-strobe start, the mask is all zeros whatever the write inputs are, and that clock is a read. This also holds when the controller strobe is flagged at the same time. Write inputs take effect from the following clock.
- R5: In a clock flagged as a controller-strobe start without the processor strobe, write inputs that indicate a write produce the matching mask in that same clock.
- R6: After any edge where a mask bit was 1, the drive enable is 0 whatever the output enable is.
- R7: While not selected, the mask is all zeros, and after that edge the drive enable is 0.
- R8: After a read started by either strobe in the first selected clock that follows a deselected clock, the drive enable stays 0. A following continuing read clock lets the drive enable rise.
- R9: After a write, continuing clocks that do not write keep the drive enable at 0. The enable returns only after a read started by a strobe.
- R10: Once read permission is held, the drive enable follows the inverted output enable at once, without waiting for a clock.
- R11: During and after synchronous reset the drive enable is 0, and the bus phase is treated as deselected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| glb_wr_n | input | 1 | Global write, active low |
| byte_wr_en_n | input | 1 | Byte-write enable, active low |
| byte_sel_n | input | NUM_BYTES | Per-lane byte selects, active low |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| strobe_proc | input | 1 | A processor strobe starts an access this clock |
| strobe_ctrl | input | 1 | A controller strobe starts an access this clock |
| selected | input | 1 | Device selected this clock (from the address controller) |
| wr_mask | output | NUM_BYTES | Per-lane write strobes to the core, active high |
| drive_en | output | 1 | Data pins may drive |

## Verification
The bench builds the block with its default of four byte lanes. This makes single-lane, two-lane, three-lane and all-lane select patterns easy to check against the global-write override. The stimulus table walks the bus phase through deselect, processor-started reads, byte and global writes, controller-started reads and writes, and the simultaneous-strobe case. Each step checks the combinational mask before the edge and the drive enable after it. Directed steps then toggle the output enable between edges and apply reset in the middle of a read.

// File: rtl/bwc_pkg.sv
package bwc_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_READ  = 2'd1,
        PH_WRITE = 2'd2
    } bus_phase_e;

    typedef struct packed {
        bus_phase_e phase;
        logic       rd_ok;
    } bus_state_t;

    localparam bus_state_t BUS_RESET = '{phase: PH_IDLE, rd_ok: 1'b0};

    function automatic logic lane_write(input logic gw_n, input logic bwe_n,
                                        input logic sel_n);
        return (!gw_n) || (!bwe_n && !sel_n);
    endfunction

    function automatic bus_state_t next_bus(input bus_state_t cur, input logic sel,
                                            input logic new_start, input logic wr_hit);
        bus_state_t nx;
        nx = cur;
        if (!sel) begin
            nx.phase = PH_IDLE;
            nx.rd_ok = 1'b0;
        end else if (wr_hit) begin
            nx.phase = PH_WRITE;
            nx.rd_ok = 1'b0;
        end else if (new_start) begin
            nx.phase = PH_READ;
            nx.rd_ok = (cur.phase != PH_IDLE);
        end else begin
            case (cur.phase)
                PH_READ: nx.rd_ok = 1'b1;
                default: nx.rd_ok = 1'b0;
            endcase
        end
        return nx;
    endfunction

endpackage

// File: rtl/bwc_write_decode.sv
module bwc_write_decode #(
    parameter int NUM_BYTES = 4
) (
    input  logic                 glb_wr_n,
    input  logic                 byte_wr_en_n,
    input  logic [NUM_BYTES-1:0] byte_sel_n,
    input  logic                 write_ok,
    output logic [NUM_BYTES-1:0] wr_mask,
    output logic                 wr_hit
);
    import bwc_pkg::*;

    logic [NUM_BYTES-1:0] lane_req;

    for (genvar g = 0; g < NUM_BYTES; g++) begin : g_lane
        assign lane_req[g] = lane_write(glb_wr_n, byte_wr_en_n, byte_sel_n[g]);
        assign wr_mask[g]  = write_ok & lane_req[g];
    end

    assign wr_hit = |wr_mask;

endmodule

// File: rtl/bwc_bus_fsm.sv
module bwc_bus_fsm (
    input  logic clk,
    input  logic rst,
    input  logic selected,
    input  logic strobe_proc,
    input  logic strobe_ctrl,
    input  logic wr_hit,
    output logic rd_valid
);
    import bwc_pkg::*;

    bus_state_t st_q;
    bus_state_t st_d;
    logic       new_start;

    assign new_start = strobe_proc | strobe_ctrl;

    always_comb begin
        st_d = next_bus(st_q, selected, new_start, wr_hit);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= BUS_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_valid = st_q.rd_ok;

endmodule

// File: rtl/bwc_ctrl.sv
module bwc_ctrl #(
    parameter int NUM_BYTES = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 glb_wr_n,
    input  logic                 byte_wr_en_n,
    input  logic [NUM_BYTES-1:0] byte_sel_n,
    input  logic                 out_en_n,
    input  logic                 strobe_proc,
    input  logic                 strobe_ctrl,
    input  logic                 selected,
    output logic [NUM_BYTES-1:0] wr_mask,
    output logic                 drive_en
);

    logic write_ok;
    logic wr_hit;
    logic rd_valid;

    // a processor-strobe start forces a read; it also wins over the controller strobe
    assign write_ok = selected & ~strobe_proc;

    bwc_write_decode #(.NUM_BYTES(NUM_BYTES)) u_dec (
        .glb_wr_n     (glb_wr_n),
        .byte_wr_en_n (byte_wr_en_n),
        .byte_sel_n   (byte_sel_n),
        .write_ok     (write_ok),
        .wr_mask      (wr_mask),
        .wr_hit       (wr_hit)
    );

    bwc_bus_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .selected    (selected),
        .strobe_proc (strobe_proc),
        .strobe_ctrl (strobe_ctrl),
        .wr_hit      (wr_hit),
        .rd_valid    (rd_valid)
    );

    assign drive_en = rd_valid & ~out_en_n;

endmodule

// File: rtl/bwc_ctrl_chk.sv
module bwc_ctrl_chk #(
    parameter int NUM_BYTES = 4
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 glb_wr_n,
    input logic                 out_en_n,
    input logic                 strobe_proc,
    input logic                 selected,
    input logic [NUM_BYTES-1:0] wr_mask,
    input logic                 drive_en
);

    AST_GW_ALL_LANES: assert property (@(posedge clk) disable iff (rst)
        (selected && !strobe_proc && !glb_wr_n) |-> (&wr_mask)); // R1

    AST_PROC_START_READ: assert property (@(posedge clk) disable iff (rst)
        strobe_proc |-> (wr_mask == '0)); // R4

    AST_WRITE_FLOATS_BUS: assert property (@(posedge clk) disable iff (rst)
        (|wr_mask) |=> !drive_en); // R6

    AST_DESEL_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        !selected |-> (wr_mask == '0)); // R7

    AST_DESEL_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
        !selected |=> !drive_en); // R7

    AST_FIRST_AFTER_DESEL: assert property (@(posedge clk) disable iff (rst)
        (selected && !$past(selected)) |=> !drive_en); // R8

    AST_OE_GATES_DRIVE: assert property (@(posedge clk) disable iff (rst)
        out_en_n |-> !drive_en); // R10

endmodule

bind bwc_ctrl bwc_ctrl_chk #(.NUM_BYTES(NUM_BYTES)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .glb_wr_n    (glb_wr_n),
    .out_en_n    (out_en_n),
    .strobe_proc (strobe_proc),
    .selected    (selected),
    .wr_mask     (wr_mask),
    .drive_en    (drive_en)
);

// File: tb/sim_bwc_ctrl.sv
module sim_bwc_ctrl;

    localparam int NB    = 4;
    localparam int NROWS = 16;

    logic          clk = 1'b0;
    logic          rst;
    logic          glb_wr_n, byte_wr_en_n, out_en_n;
    logic          strobe_proc, strobe_ctrl, selected;
    logic [NB-1:0] byte_sel_n;
    logic [NB-1:0] wr_mask;
    logic          drive_en;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    bwc_ctrl #(.NUM_BYTES(NB)) u0 (
        .clk(clk), .rst(rst), .glb_wr_n(glb_wr_n), .byte_wr_en_n(byte_wr_en_n),
        .byte_sel_n(byte_sel_n), .out_en_n(out_en_n), .strobe_proc(strobe_proc),
        .strobe_ctrl(strobe_ctrl), .selected(selected), .wr_mask(wr_mask),
        .drive_en(drive_en)
    );

    // [14]sel [13]proc [12]ctrl [11]gw_n [10]bwe_n [9:6]bsel_n [5]oe_n [4:1]mask [0]drive
    localparam logic [14:0] VEC [NROWS] = '{
        15'b0_0_0_0_1_1111_0_0000_0, //  0 R7 deselected, global write ignored
        15'b1_1_0_0_1_1111_0_0000_0, //  1 R4 R8 processor start after deselect
        15'b1_0_0_1_1_1111_0_0000_1, //  2 R8 continuing read drives
        15'b1_0_0_1_1_1111_1_0000_0, //  3 R10 output enable high
        15'b1_1_0_1_0_1111_0_0000_1, //  4 R3 byte enable low, no lane selected
        15'b1_0_0_1_0_1010_0_0101_0, //  5 R2 R6 byte write lanes 0 and 2
        15'b1_0_0_1_1_1111_0_0000_0, //  6 R9 bus stays floating after write
        15'b1_0_0_0_1_0000_0_1111_0, //  7 R1 global write overrides
        15'b1_0_1_1_1_1111_0_0000_1, //  8 R9 controller read restores drive
        15'b1_0_1_1_0_0111_0_1000_0, //  9 R5 controller-start write lane 3
        15'b1_1_1_1_0_0000_0_0000_1, // 10 R4 both strobes: processor wins
        15'b1_0_0_1_1_0000_0_0000_1, // 11 R3 both write controls high
        15'b0_0_0_1_1_1111_0_0000_0, // 12 R7 deselect
        15'b1_0_1_1_1_1111_0_0000_0, // 13 R8 controller start after deselect
        15'b1_0_0_1_1_1111_0_0000_1, // 14 R8 continuing read drives
        15'b0_0_0_0_0_0000_0_0000_0  // 15 R7 deselected with all writes asserted
    };

    function automatic string row_tag(input int i);
        case (i)
            0, 12, 15:   return "R7";
            1:           return "R4";
            2, 13, 14:   return "R8";
            3:           return "R10";
            4, 11:       return "R3";
            5:           return "R2";
            6, 8:        return "R9";
            7:           return "R1";
            9:           return "R5";
            10:          return "R4";
            default:     return "R?";
        endcase
    endfunction

    task automatic check(input string tag, input logic [NB-1:0] act,
                         input logic [NB-1:0] exp, input string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
        end
    endtask

    task automatic apply(input logic [14:0] v);
        selected     = v[14];
        strobe_proc  = v[13];
        strobe_ctrl  = v[12];
        glb_wr_n     = v[11];
        byte_wr_en_n = v[10];
        byte_sel_n   = v[9:6];
        out_en_n     = v[5];
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #100000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst = 1'b1;
        apply(15'b0_0_0_1_1_1111_0_0000_0);
        repeat (3) @(posedge clk);
        #1;
        check("R11", {3'b0, drive_en}, 4'b0, "drive in reset");
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NROWS; i++) begin
            @(negedge clk);
            apply(VEC[i]);
            #1;
            check(row_tag(i), wr_mask, VEC[i][4:1], $sformatf("mask row %0d", i));
            @(posedge clk);
            #1;
            check(row_tag(i), {3'b0, drive_en}, {3'b0, VEC[i][0]},
                  $sformatf("drive row %0d", i));
        end

        // R10: output enable acts between edges once read permission is held
        @(negedge clk);
        apply(15'b1_1_0_1_1_1111_0_0000_0);
        @(negedge clk);
        apply(15'b1_0_0_1_1_1111_0_0000_0);
        @(posedge clk);
        #1;
        check("R10", {3'b0, drive_en}, 4'b0001, "drive with oe low");
        out_en_n = 1'b1;
        #0.5;
        check("R10", {3'b0, drive_en}, 4'b0000, "async oe high");
        out_en_n = 1'b0;
        #0.5;
        check("R10", {3'b0, drive_en}, 4'b0001, "async oe low");

        // R11: reset in the middle of a read floats the bus and marks deselect
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        check("R11", {3'b0, drive_en}, 4'b0, "drive after reset");
        @(negedge clk);
        rst = 1'b0;
        apply(15'b1_1_0_1_1_1111_0_0000_0);
        @(posedge clk);
        #1;
        check("R11", {3'b0, drive_en}, 4'b0, "first read after reset");

        @(negedge clk);
        finish_run();
    end

endmodule